// File: doc/BRIEF.md
# In-Order Retire Controller

This block decides, every cycle, which entries at the oldest end of a reorder buffer leave the machine. It sees a window of the oldest `SCAN` entries, each with a sequence number and a set of status flags. It walks them from oldest to youngest and retires entries until one of three things happens: it reaches the commit width `W`, it meets an entry that is not present or not ready, or it meets an entry that needs special handling. Entries that were squashed are dropped, and they do not use up commit width.

Serialising instructions, unexecuted loads and faulting instructions are not retired. For these the block signals backward instead. A serialising instruction gets a request to execute it non-speculatively. An unexecuted load gets a replay request that marks it uncached. A fault gets a trap request. Serialising and faulting heads may only act when they are the first commit candidate of the cycle and the store writeback path reports no pending stores. Otherwise they wait.

Retire, squash-drop and can-commit-clear masks are combinational. Bit k of each mask refers to window slot k, and slot 0 is the oldest. The trap-pending state, the error flag, the done sequence number and the counters are registered.

Top module: `retire_ctl`

## Requirements
- R1: At most `W` non-squashed entries commit per cycle. The retire mask `ret_o` is always a contiguous run starting at slot 0. Scanning stops at the first slot that is not valid or not ready, and it also stops once `W` entries have committed.
- R2: A valid, ready, squashed entry is retired. Its bit is set in both `ret_o` and `sq_ret_o`. It does not count toward `W`, and it adds one to the squash counter `cnt_squash_o`.
- R3: An unexecuted entry flagged non-speculative, store-conditional, memory barrier or write barrier is handled as follows:
  - It stalls with no request while `st_pend_i` is high or while an entry has already committed this cycle.
  - Otherwise it pulses `nspec_req_o` with its sequence number on `nspec_seq_o`, sets its bit in `clr_cc_o`, and adds one to `cnt_nspec_o`.
  - Scanning stops at this entry in both cases.
- R4: An unexecuted load that is not serialising pulses `unc_req_o` with its sequence number on `unc_seq_o` and sets its bit in `clr_cc_o`. This happens whatever the value of `st_pend_i`, and scanning stops there.
- R5: An executed entry with its fault flag set never retires.
  - If it is the first candidate of the cycle and `st_pend_i` is low, it pulses `trap_req_o`. `trap_pend_o` is set from the next cycle.
  - While `trap_pend_o` is high, nothing retires and no request is made.
  - `trap_ack_i` clears `trap_pend_o`.
- R6: `done_seq_o` takes the sequence number of the youngest entry committed in a cycle, one clock later. It holds its value in cycles with no commit.
- R7: `cnt_commit_o` adds the number of entries committed each cycle. `cnt_arch_o` adds the same number, minus entries flagged nop/prefetch.
- R8: `cnt_full_o` counts the cycles in which exactly `W` entries committed.
- R9: An unexecuted entry that is neither serialising nor a load stalls, and it sets the sticky flag `err_o`. Only reset clears `err_o`.
- R10: After reset, `done_seq_o`, all counters, `trap_pend_o` and `err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| st_pend_i | input | 1 | Stores still awaiting writeback |
| trap_ack_i | input | 1 | Trap handled; clears trap pending |
| hd_vld_i | input | SCAN | Slot holds an entry |
| hd_rdy_i | input | SCAN | Entry may be considered for commit |
| hd_sq_i | input | SCAN | Entry was squashed |
| hd_exe_i | input | SCAN | Entry has executed |
| hd_nspec_i | input | SCAN | Non-speculative instruction |
| hd_stc_i | input | SCAN | Store-conditional |
| hd_mbar_i | input | SCAN | Memory barrier |
| hd_wbar_i | input | SCAN | Write barrier |
| hd_ld_i | input | SCAN | Load |
| hd_flt_i | input | SCAN | Entry carries a fault |
| hd_nop_i | input | SCAN | Nop or instruction prefetch |
| hd_seq_i | input | SCAN*SW | Sequence numbers, slot k at bits k*SW upward |
| ret_o | output | SCAN | Entries removed this cycle |
| sq_ret_o | output | SCAN | Removed entries that were squashed |
| clr_cc_o | output | SCAN | Clear can-commit for this slot |
| nspec_req_o | output | 1 | Non-speculative execute request |
| nspec_seq_o | output | SW | Sequence number of that request |
| unc_req_o | output | 1 | Uncached load replay request |
| unc_seq_o | output | SW | Sequence number of that request |
| trap_req_o | output | 1 | Trap request |
| trap_pend_o | output | 1 | Trap pending, commit blocked |
| err_o | output | 1 | Sticky unknown-class error |
| done_seq_o | output | SW | Youngest committed sequence number |
| cnt_commit_o | output | CW | Committed entries |
| cnt_arch_o | output | CW | Committed entries excluding nops |
| cnt_squash_o | output | CW | Squashed entries dropped |
| cnt_full_o | output | CW | Cycles at full width |
| cnt_nspec_o | output | CW | Non-speculative requests sent |

## Verification
The bench builds the block with a five-slot window, a commit width of three and eight-bit sequence numbers.

Because the window is wider than the width, several cases become reachable:
- The width limit can stop the scan while ready entries still sit behind it.
- Squashed entries can sit both inside the width, where they are dropped, and past it, where they are left in place.
- A squashed entry ahead of a serialising one can test that dropping does not spoil the first-candidate rule.

A width of three also keeps full-width cycles frequent in the vector table.

// File: rtl/retire_pkg.sv
package retire_pkg;
  localparam int NUM_CNT    = 5;
  localparam int CNT_COMMIT = 0;
  localparam int CNT_ARCH   = 1;
  localparam int CNT_SQUASH = 2;
  localparam int CNT_FULL   = 3;
  localparam int CNT_NSPEC  = 4;
endpackage

// File: rtl/retire_scan.sv
module retire_scan #(
  parameter int SCAN = 6,
  parameter int W    = 4,
  parameter int SW   = 16,
  parameter int IW   = $clog2(SCAN + 1)
) (
  input  logic                 st_pend_i,
  input  logic                 block_i,
  input  logic [SCAN-1:0]      vld_i,
  input  logic [SCAN-1:0]      rdy_i,
  input  logic [SCAN-1:0]      sq_i,
  input  logic [SCAN-1:0]      exe_i,
  input  logic [SCAN-1:0]      nspec_i,
  input  logic [SCAN-1:0]      stc_i,
  input  logic [SCAN-1:0]      mbar_i,
  input  logic [SCAN-1:0]      wbar_i,
  input  logic [SCAN-1:0]      ld_i,
  input  logic [SCAN-1:0]      flt_i,
  input  logic [SCAN-1:0]      nop_i,
  input  logic [SCAN*SW-1:0]   seq_i,
  output logic [SCAN-1:0]      ret_o,
  output logic [SCAN-1:0]      sqr_o,
  output logic [SCAN-1:0]      clr_o,
  output logic                 ns_req_o,
  output logic [SW-1:0]        ns_seq_o,
  output logic                 unc_req_o,
  output logic [SW-1:0]        unc_seq_o,
  output logic                 trap_req_o,
  output logic                 bad_o,
  output logic                 done_vld_o,
  output logic [SW-1:0]        done_seq_o,
  output logic [IW-1:0]        n_commit_o,
  output logic [IW-1:0]        n_arch_o,
  output logic [IW-1:0]        n_sq_o,
  output logic                 full_o
);
  localparam int NW = $clog2(W + 1);

  logic [SCAN-1:0] ser;
  logic [SW-1:0]   seq_a [SCAN];

  // per-slot decode: serialising class and sequence number slice
  for (genvar k = 0; k < SCAN; k++) begin : g_slot
    assign ser[k]   = nspec_i[k] | stc_i[k] | mbar_i[k] | wbar_i[k];
    assign seq_a[k] = seq_i[k*SW +: SW];
  end

  // oldest-first walk; n counts real commits, first candidate means n == 0
  always_comb begin
    logic          stop;
    logic          act;
    logic [NW-1:0] n;
    logic [IW-1:0] a;
    logic [IW-1:0] s;
    stop       = block_i;
    n          = '0;
    a          = '0;
    s          = '0;
    ret_o      = '0;
    sqr_o      = '0;
    clr_o      = '0;
    ns_req_o   = 1'b0;
    ns_seq_o   = '0;
    unc_req_o  = 1'b0;
    unc_seq_o  = '0;
    trap_req_o = 1'b0;
    bad_o      = 1'b0;
    done_vld_o = 1'b0;
    done_seq_o = '0;
    for (int k = 0; k < SCAN; k++) begin
      act = !stop && (n != NW'(W)) && vld_i[k] && rdy_i[k];
      if (act && sq_i[k]) begin
        ret_o[k] = 1'b1;
        sqr_o[k] = 1'b1;
        s        = s + 1'b1;
      end else if (act && exe_i[k] && !flt_i[k]) begin
        ret_o[k]   = 1'b1;
        n          = n + 1'b1;
        done_vld_o = 1'b1;
        done_seq_o = seq_a[k];
        if (!nop_i[k]) a = a + 1'b1;
      end else begin
        if (act) begin
          if (exe_i[k]) begin
            if (!st_pend_i && n == '0) trap_req_o = 1'b1;
          end else if (ser[k]) begin
            if (!st_pend_i && n == '0) begin
              ns_req_o = 1'b1;
              ns_seq_o = seq_a[k];
              clr_o[k] = 1'b1;
            end
          end else if (ld_i[k]) begin
            unc_req_o = 1'b1;
            unc_seq_o = seq_a[k];
            clr_o[k]  = 1'b1;
          end else begin
            bad_o = 1'b1;
          end
        end
        stop = 1'b1;
      end
    end
    n_commit_o = IW'(n);
    n_arch_o   = a;
    n_sq_o     = s;
    full_o     = (n == NW'(W));
  end
endmodule

// File: rtl/retire_stats.sv
module retire_stats #(
  parameter int NCNT = 5,
  parameter int CW   = 16,
  parameter int IW   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCNT-1:0][IW-1:0]   inc_i,
  output logic [NCNT-1:0][CW-1:0]   cnt_o
);
  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_en;

    assign cnt_en = (inc_i[c] != '0);
    assign cnt_d  = cnt_q + CW'(inc_i[c]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign cnt_o[c] = cnt_q;
  end
endmodule

// File: rtl/retire_ctl.sv
module retire_ctl
  import retire_pkg::*;
#(
  parameter int SCAN = 6,
  parameter int W    = 4,
  parameter int SW   = 16,
  parameter int CW   = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                st_pend_i,
  input  logic                trap_ack_i,
  input  logic [SCAN-1:0]     hd_vld_i,
  input  logic [SCAN-1:0]     hd_rdy_i,
  input  logic [SCAN-1:0]     hd_sq_i,
  input  logic [SCAN-1:0]     hd_exe_i,
  input  logic [SCAN-1:0]     hd_nspec_i,
  input  logic [SCAN-1:0]     hd_stc_i,
  input  logic [SCAN-1:0]     hd_mbar_i,
  input  logic [SCAN-1:0]     hd_wbar_i,
  input  logic [SCAN-1:0]     hd_ld_i,
  input  logic [SCAN-1:0]     hd_flt_i,
  input  logic [SCAN-1:0]     hd_nop_i,
  input  logic [SCAN*SW-1:0]  hd_seq_i,
  output logic [SCAN-1:0]     ret_o,
  output logic [SCAN-1:0]     sq_ret_o,
  output logic [SCAN-1:0]     clr_cc_o,
  output logic                nspec_req_o,
  output logic [SW-1:0]       nspec_seq_o,
  output logic                unc_req_o,
  output logic [SW-1:0]       unc_seq_o,
  output logic                trap_req_o,
  output logic                trap_pend_o,
  output logic                err_o,
  output logic [SW-1:0]       done_seq_o,
  output logic [CW-1:0]       cnt_commit_o,
  output logic [CW-1:0]       cnt_arch_o,
  output logic [CW-1:0]       cnt_squash_o,
  output logic [CW-1:0]       cnt_full_o,
  output logic [CW-1:0]       cnt_nspec_o
);
  localparam int IW = $clog2(SCAN + 1);

  logic                       bad, done_vld, full;
  logic [SW-1:0]              done_nxt;
  logic [IW-1:0]              n_commit, n_arch, n_sq;
  logic [NUM_CNT-1:0][IW-1:0] inc;
  logic [NUM_CNT-1:0][CW-1:0] cnt;

  logic          trap_q, trap_d, trap_en;
  logic          err_q, err_d, err_en;
  logic [SW-1:0] done_q;

  retire_scan #(.SCAN(SCAN), .W(W), .SW(SW), .IW(IW)) u_scan (
    .st_pend_i (st_pend_i),
    .block_i   (trap_q),
    .vld_i     (hd_vld_i),
    .rdy_i     (hd_rdy_i),
    .sq_i      (hd_sq_i),
    .exe_i     (hd_exe_i),
    .nspec_i   (hd_nspec_i),
    .stc_i     (hd_stc_i),
    .mbar_i    (hd_mbar_i),
    .wbar_i    (hd_wbar_i),
    .ld_i      (hd_ld_i),
    .flt_i     (hd_flt_i),
    .nop_i     (hd_nop_i),
    .seq_i     (hd_seq_i),
    .ret_o     (ret_o),
    .sqr_o     (sq_ret_o),
    .clr_o     (clr_cc_o),
    .ns_req_o  (nspec_req_o),
    .ns_seq_o  (nspec_seq_o),
    .unc_req_o (unc_req_o),
    .unc_seq_o (unc_seq_o),
    .trap_req_o(trap_req_o),
    .bad_o     (bad),
    .done_vld_o(done_vld),
    .done_seq_o(done_nxt),
    .n_commit_o(n_commit),
    .n_arch_o  (n_arch),
    .n_sq_o    (n_sq),
    .full_o    (full)
  );

  always_comb begin
    inc             = '0;
    inc[CNT_COMMIT] = n_commit;
    inc[CNT_ARCH]   = n_arch;
    inc[CNT_SQUASH] = n_sq;
    inc[CNT_FULL]   = IW'(full);
    inc[CNT_NSPEC]  = IW'(nspec_req_o);
  end

  retire_stats #(.NCNT(NUM_CNT), .CW(CW), .IW(IW)) u_stats (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (inc),
    .cnt_o (cnt)
  );

  // next-state for trap-pending and error flags
  always_comb begin
    trap_en = trap_req_o | trap_ack_i;
    trap_d  = trap_req_o;
    err_en  = bad;
    err_d   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      trap_q <= 1'b0;
    else if (trap_en) trap_q <= trap_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       done_q <= '0;
    else if (done_vld) done_q <= done_nxt;
  end

  assign trap_pend_o  = trap_q;
  assign err_o        = err_q;
  assign done_seq_o   = done_q;
  assign cnt_commit_o = cnt[CNT_COMMIT];
  assign cnt_arch_o   = cnt[CNT_ARCH];
  assign cnt_squash_o = cnt[CNT_SQUASH];
  assign cnt_full_o   = cnt[CNT_FULL];
  assign cnt_nspec_o  = cnt[CNT_NSPEC];
endmodule

// File: rtl/retire_ctl_chk.sv
module retire_ctl_chk #(
  parameter int SCAN = 6,
  parameter int W    = 4,
  parameter int SW   = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            st_pend_i,
  input logic [SCAN-1:0] ret_o,
  input logic [SCAN-1:0] sq_ret_o,
  input logic [SCAN-1:0] clr_cc_o,
  input logic            nspec_req_o,
  input logic            unc_req_o,
  input logic            trap_req_o,
  input logic            trap_pend_o,
  input logic            err_o,
  input logic [SW-1:0]   done_seq_o
);
  AST_WIDTH_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ret_o & ~sq_ret_o) <= W); // R1

  AST_RET_PREFIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ret_o + SCAN'(1)) & ret_o) == '0); // R1

  AST_SQ_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_ret_o & ~ret_o) == '0); // R2

  AST_NSPEC_NO_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nspec_req_o |-> !st_pend_i); // R3

  AST_ONE_BACK_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nspec_req_o, unc_req_o, trap_req_o})); // R3

  AST_CLR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(clr_cc_o) == 32'(nspec_req_o) + 32'(unc_req_o)); // R4

  AST_TRAP_NO_STORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |-> !st_pend_i); // R5

  AST_TRAP_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_o |=> trap_pend_o); // R5

  AST_PEND_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_pend_o |-> (ret_o == '0 && !trap_req_o && !nspec_req_o && !unc_req_o)); // R5

  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ret_o & ~sq_ret_o) == '0) |=> $stable(done_seq_o)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R9
endmodule

bind retire_ctl retire_ctl_chk #(.SCAN(SCAN), .W(W), .SW(SW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .st_pend_i  (st_pend_i),
  .ret_o      (ret_o),
  .sq_ret_o   (sq_ret_o),
  .clr_cc_o   (clr_cc_o),
  .nspec_req_o(nspec_req_o),
  .unc_req_o  (unc_req_o),
  .trap_req_o (trap_req_o),
  .trap_pend_o(trap_pend_o),
  .err_o      (err_o),
  .done_seq_o (done_seq_o)
);

// File: tb/retire_ctl_tb_top.sv
module retire_ctl_tb_top;
  localparam int SCAN = 5;
  localparam int W    = 3;
  localparam int SW   = 8;
  localparam int CW   = 16;

  // slot kind codes used by the stimulus table
  localparam logic [3:0] K_E = 4'd0, K_C = 4'd1, K_N = 4'd2, K_S = 4'd3, K_R = 4'd4,
                         K_NS = 4'd5, K_LD = 4'd6, K_FT = 4'd7, K_BAD = 4'd8,
                         K_MB = 4'd9, K_SC = 4'd10, K_WB = 4'd11;

  typedef struct packed {
    logic [19:0] kinds;  // slot k kind at bits 4k+3:4k
    logic        st;
    logic [7:0]  base;
    logic [4:0]  ret;
    logic [4:0]  sq;
    logic [4:0]  clr;
    logic        ns;
    logic        unc;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{20'h11111, 1'b0, 8'd10,  5'b00111, 5'b00000, 5'b00000, 1'b0, 1'b0},
    '{20'h11313, 1'b0, 8'd20,  5'b11111, 5'b00101, 5'b00000, 1'b0, 1'b0},
    '{20'h11421, 1'b0, 8'd30,  5'b00011, 5'b00000, 5'b00000, 1'b0, 1'b0},
    '{20'h11115, 1'b0, 8'd40,  5'b00000, 5'b00000, 5'b00001, 1'b1, 1'b0},
    '{20'h11115, 1'b1, 8'd50,  5'b00000, 5'b00000, 5'b00000, 1'b0, 1'b0},
    '{20'h00151, 1'b0, 8'd60,  5'b00001, 5'b00000, 5'b00000, 1'b0, 1'b0},
    '{20'h00153, 1'b0, 8'd70,  5'b00001, 5'b00001, 5'b00010, 1'b1, 1'b0},
    '{20'h00161, 1'b1, 8'd80,  5'b00001, 5'b00000, 5'b00010, 1'b0, 1'b1},
    '{20'h00019, 1'b0, 8'd90,  5'b00000, 5'b00000, 5'b00001, 1'b1, 1'b0},
    '{20'h00A11, 1'b0, 8'd100, 5'b00011, 5'b00000, 5'b00000, 1'b0, 1'b0},
    '{20'h0000B, 1'b0, 8'd110, 5'b00000, 5'b00000, 5'b00001, 1'b1, 1'b0},
    '{20'h00110, 1'b0, 8'd120, 5'b00000, 5'b00000, 5'b00000, 1'b0, 1'b0},
    '{20'h22222, 1'b0, 8'd130, 5'b00111, 5'b00000, 5'b00000, 1'b0, 1'b0},
    '{20'h33111, 1'b0, 8'd140, 5'b00111, 5'b00000, 5'b00000, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic st_pend, trap_ack;
  logic [SCAN-1:0] vld, rdy, sq, exe, nspec, stc, mbar, wbar, ld, flt, nop;
  logic [SCAN*SW-1:0] seq;
  logic [SCAN-1:0] ret, sq_ret, clr;
  logic nspec_req, unc_req, trap_req, trap_pend, err;
  logic [SW-1:0] nspec_seq, unc_seq, done_seq;
  logic [CW-1:0] c_commit, c_arch, c_squash, c_full, c_nspec;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  retire_ctl #(.SCAN(SCAN), .W(W), .SW(SW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .st_pend_i(st_pend), .trap_ack_i(trap_ack),
    .hd_vld_i(vld), .hd_rdy_i(rdy), .hd_sq_i(sq), .hd_exe_i(exe),
    .hd_nspec_i(nspec), .hd_stc_i(stc), .hd_mbar_i(mbar), .hd_wbar_i(wbar),
    .hd_ld_i(ld), .hd_flt_i(flt), .hd_nop_i(nop), .hd_seq_i(seq),
    .ret_o(ret), .sq_ret_o(sq_ret), .clr_cc_o(clr),
    .nspec_req_o(nspec_req), .nspec_seq_o(nspec_seq),
    .unc_req_o(unc_req), .unc_seq_o(unc_seq),
    .trap_req_o(trap_req), .trap_pend_o(trap_pend), .err_o(err),
    .done_seq_o(done_seq),
    .cnt_commit_o(c_commit), .cnt_arch_o(c_arch), .cnt_squash_o(c_squash),
    .cnt_full_o(c_full), .cnt_nspec_o(c_nspec)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [19:0] kinds, input logic st, input logic [7:0] base);
    st_pend = st;
    for (int k = 0; k < SCAN; k++) begin
      logic [3:0] kd;
      kd       = kinds[4*k +: 4];
      vld[k]   = (kd != K_E);
      rdy[k]   = (kd != K_R);
      sq[k]    = (kd == K_S);
      exe[k]   = (kd == K_C) || (kd == K_N) || (kd == K_FT);
      nspec[k] = (kd == K_NS);
      ld[k]    = (kd == K_LD);
      flt[k]   = (kd == K_FT);
      mbar[k]  = (kd == K_MB);
      stc[k]   = (kd == K_SC);
      wbar[k]  = (kd == K_WB);
      nop[k]   = (kd == K_N);
      seq[k*SW +: SW] = base + SW'(k);
    end
  endtask

  function automatic int low_idx(input logic [4:0] m);
    for (int k = 0; k < 5; k++) if (m[k]) return k;
    return 0;
  endfunction

  function automatic int high_idx(input logic [4:0] m);
    int h = 0;
    for (int k = 0; k < 5; k++) if (m[k]) h = k;
    return h;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] exp_done;
    int e_commit, e_arch, e_sq, e_full, e_ns;
    exp_done = '0;
    e_commit = 0; e_arch = 0; e_sq = 0; e_full = 0; e_ns = 0;
    rst_n = 1'b0;
    trap_ack = 1'b0;
    drive(20'h0, 1'b0, 8'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10", "done_seq", done_seq, 0);
    chk("R10", "cnt_commit", c_commit, 0);
    chk("R10", "cnt_squash", c_squash, 0);
    chk("R10", "trap_pend", trap_pend, 0);
    chk("R10", "err", err, 0);

    for (int i = 0; i < NV; i++) begin
      logic [4:0] cm;
      @(negedge clk);
      drive(VEC[i].kinds, VEC[i].st, VEC[i].base);
      #1;
      chk("R1", "ret", ret, VEC[i].ret);
      chk("R2", "sq_ret", sq_ret, VEC[i].sq);
      chk("R3", "clr_cc", clr, VEC[i].clr);
      chk("R3", "nspec_req", nspec_req, VEC[i].ns);
      chk("R4", "unc_req", unc_req, VEC[i].unc);
      if (VEC[i].ns)  chk("R3", "nspec_seq", nspec_seq, VEC[i].base + low_idx(VEC[i].clr));
      if (VEC[i].unc) chk("R4", "unc_seq", unc_seq, VEC[i].base + low_idx(VEC[i].clr));
      cm = VEC[i].ret & ~VEC[i].sq;
      if (cm != 0) exp_done = VEC[i].base + SW'(high_idx(cm));
      e_commit += $countones(cm);
      for (int k = 0; k < 5; k++)
        if (cm[k] && VEC[i].kinds[4*k +: 4] != K_N) e_arch++;
      e_sq += $countones(VEC[i].sq);
      if ($countones(cm) == W) e_full++;
      if (VEC[i].ns) e_ns++;
      @(posedge clk);
      #1;
      chk("R6", "done_seq", done_seq, exp_done);
    end
    chk("R7", "cnt_commit", c_commit, e_commit);
    chk("R7", "cnt_arch", c_arch, e_arch);
    chk("R2", "cnt_squash", c_squash, e_sq);
    chk("R8", "cnt_full", c_full, e_full);
    chk("R3", "cnt_nspec", c_nspec, e_ns);

    // R5 fault behind a commit must wait
    @(negedge clk); drive(20'h00071, 1'b0, 8'd150); #1;
    chk("R5", "ret fault second", ret, 5'b00001);
    chk("R5", "trap_req fault second", trap_req, 0);
    // R5 fault first but stores pending
    @(negedge clk); drive(20'h00007, 1'b1, 8'd152); #1;
    chk("R5", "trap_req stores", trap_req, 0);
    chk("R5", "ret stores", ret, 0);
    // R5 fault first, no stores: trap
    @(negedge clk); drive(20'h00007, 1'b0, 8'd154); #1;
    chk("R5", "trap_req", trap_req, 1);
    chk("R5", "ret on trap", ret, 0);
    @(posedge clk); #1;
    chk("R5", "trap_pend set", trap_pend, 1);
    chk("R6", "done after fault", done_seq, 150);
    // R5 pending blocks retire
    @(negedge clk); drive(20'h00111, 1'b0, 8'd156); #1;
    chk("R5", "ret while pending", ret, 0);
    chk("R5", "trap_req while pending", trap_req, 0);
    @(negedge clk); drive(20'h0, 1'b0, 8'd0); trap_ack = 1'b1;
    @(negedge clk); trap_ack = 1'b0; #1;
    chk("R5", "trap_pend cleared", trap_pend, 0);
    @(negedge clk); drive(20'h00001, 1'b0, 8'd160); #1;
    chk("R5", "ret after ack", ret, 5'b00001);

    // R9 unknown unexecuted class
    @(negedge clk); drive(20'h00008, 1'b0, 8'd170); #1;
    chk("R9", "ret on unknown", ret, 0);
    chk("R9", "clr on unknown", clr, 0);
    @(posedge clk); #1;
    chk("R9", "err set", err, 1);
    @(negedge clk); drive(20'h00011, 1'b0, 8'd180); #1;
    chk("R9", "ret after error", ret, 5'b00011);
    @(posedge clk); #1;
    chk("R9", "err sticky", err, 1);
    chk("R6", "done after error", done_seq, 181);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule